// File: doc/BRIEF.md
# Timer-Shared Parallel I/O Port

This block is a small parallel port whose pins double as timer pins. A set of bidirectional capture/compare pins, a pair of output-only PWM pins and two input-only lines (a pulse-accumulator input and an auxiliary clock input) all pass through it. Software programs a per-pin direction register and a data latch over a simple register bus. The block then decides, pin by pin, whether an enabled timer output, the data latch or nothing drives the pin.

Every pin level is resolved into an effective value. For a driven pin this is the value being driven. For an undriven pin it is the level arriving from outside. The effective values pass through a two-flop synchronizer. The synchronized values feed the data readback and the rising/falling edge strobes used by the capture engines. Because the latch feeds this path, a write to the data latch on a latch-driven pin can raise a capture edge. The capture/compare, PWM and accumulator engines are outside the block. They appear only as enable and value inputs and as strobe and synchronized-level outputs.

Top module: `tsio_port`

## Requirements
- R1: There are N_CC capture/compare pins with output enables, N_PWM PWM pins with no enable, and two input-only lines (pulse accumulator, auxiliary clock) with no output.
- R2: A capture/compare pin with compare disabled is driven (cc_pin_oe=1) when its direction bit is 1 and is high impedance (cc_pin_oe=0) when its direction bit is 0.
- R3: A read of address 0 returns the effective level of every pin, two clocks after a change. This holds for pins owned by a timer function too. Bits [N_CC-1:0] are the capture/compare pins and bits [N_CC+N_PWM-1:N_CC] are the PWM pins.
- R4: While compare is enabled on a pin, writes to the data latch are stored but do not change that pin's output.
- R5: When compare is disabled on a pin whose direction bit is 1, the pin at once drives the last value written to its latch bit.
- R6: cap_rise/cap_fall pulse for exactly one clock, two clocks after the effective level of a capture/compare pin changes. A latch write to a latch-driven pin produces such an edge.
- R7: Reset clears the direction register (all inputs) and the data latch to zero.
- R8: A read of address 2 returns the synchronized pulse-accumulator input in bit 0 and the auxiliary clock input in bit 1. The same levels appear on acc_sync and aux_sync.
- R9: A pulse that lasts less than one clock and falls between two rising clock edges produces no edge strobe. A pulse of three clocks is always seen.
- R10: A PWM pin outputs pwm_val when pwm_en is set, and otherwise its latch bit.
- R11: Address 1 reads and writes the direction bits in [N_CC-1:0], and its upper bits read as zero. Address 3 reads as zero. Writes to addresses 2 and 3 change nothing.
- R12: An enabled compare function drives its pin with cmp_val whatever the direction bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 input status) |
| bus_wdata | input | N_CC+N_PWM | Write data |
| bus_rdata | output | N_CC+N_PWM | Read data for bus_addr |
| cc_pin_in | input | N_CC | Level arriving at each capture/compare pin |
| cc_pin_out | output | N_CC | Value driven on each capture/compare pin |
| cc_pin_oe | output | N_CC | Output enable of each capture/compare pin |
| pwm_pin_out | output | N_PWM | PWM pin outputs |
| acc_pin_in | input | 1 | Pulse-accumulator input line |
| aux_pin_in | input | 1 | Auxiliary clock input line |
| cmp_en | input | N_CC | Output compare owns the pin |
| cmp_val | input | N_CC | Output compare level |
| pwm_en | input | N_PWM | PWM engine owns the pin |
| pwm_val | input | N_PWM | PWM engine level |
| cap_rise | output | N_CC | One-clock rising-edge strobe per capture/compare pin |
| cap_fall | output | N_CC | One-clock falling-edge strobe per capture/compare pin |
| acc_sync | output | 1 | Synchronized pulse-accumulator level |
| aux_sync | output | 1 | Synchronized auxiliary clock level |

## Verification
The hardest case to reach is a capture edge that software causes, with no change at the pin. It needs a latch-driven pin whose latch bit changes while compare is off. A second hard case is a write that lands while compare owns the pin and must stay invisible until compare releases it. The bench sets the direction bit first and then rewrites the data latch. It counts the clocks from the write edge to the strobe. It then repeats the write with compare enabled, checks that the pin holds still, and drops compare to see the stored value appear. Sub-cycle glitches are placed between two clock edges with fine delays to confirm that no strobe appears.

// File: rtl/tsio_pkg.sv
package tsio_pkg;
    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    localparam int STAT_ACC_BIT = 0;
    localparam int STAT_AUX_BIT = 1;
endpackage

// File: rtl/tsio_sync.sv
module tsio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

    // Warm-up count so the lag check never reaches before reset release
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    p_lag_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/tsio_edge.sv
module tsio_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign rise = level & ~e_q.prev;
    assign fall = ~level & e_q.prev;

    for (genvar i = 0; i < W; i++) begin : g_chk
        p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
        p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]);
    end
endmodule

// File: rtl/tsio_pin_mux.sv
module tsio_pin_mux #(
    parameter int N_CC  = 4,
    parameter int N_PWM = 2
) (
    input  logic [N_CC-1:0]        dir,
    input  logic [N_CC+N_PWM-1:0]  latch,
    input  logic [N_CC-1:0]        cmp_en,
    input  logic [N_CC-1:0]        cmp_val,
    input  logic [N_PWM-1:0]       pwm_en,
    input  logic [N_PWM-1:0]       pwm_val,
    input  logic [N_CC-1:0]        cc_pin_in,
    output logic [N_CC-1:0]        cc_out,
    output logic [N_CC-1:0]        cc_oe,
    output logic [N_PWM-1:0]       pwm_out,
    output logic [N_CC+N_PWM-1:0]  eff
);
    // Capture/compare pins: timer output first, then latch, then high-Z
    for (genvar i = 0; i < N_CC; i++) begin : g_cc
        always_comb begin
            if (cmp_en[i]) begin
                cc_out[i] = cmp_val[i];
                cc_oe[i]  = 1'b1;
            end else if (dir[i]) begin
                cc_out[i] = latch[i];
                cc_oe[i]  = 1'b1;
            end else begin
                cc_out[i] = latch[i];
                cc_oe[i]  = 1'b0;
            end
            eff[i] = cc_oe[i] ? cc_out[i] : cc_pin_in[i];
        end
    end

    // PWM pins are always outputs
    for (genvar j = 0; j < N_PWM; j++) begin : g_pwm
        always_comb begin
            pwm_out[j]     = pwm_en[j] ? pwm_val[j] : latch[N_CC+j];
            eff[N_CC+j]    = pwm_out[j];
        end
    end
endmodule

// File: rtl/tsio_port.sv
module tsio_port
    import tsio_pkg::*;
#(
    parameter int N_CC  = 4,
    parameter int N_PWM = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [1:0]             bus_addr,
    input  logic [N_CC+N_PWM-1:0]  bus_wdata,
    output logic [N_CC+N_PWM-1:0]  bus_rdata,
    input  logic [N_CC-1:0]        cc_pin_in,
    output logic [N_CC-1:0]        cc_pin_out,
    output logic [N_CC-1:0]        cc_pin_oe,
    output logic [N_PWM-1:0]       pwm_pin_out,
    input  logic                   acc_pin_in,
    input  logic                   aux_pin_in,
    input  logic [N_CC-1:0]        cmp_en,
    input  logic [N_CC-1:0]        cmp_val,
    input  logic [N_PWM-1:0]       pwm_en,
    input  logic [N_PWM-1:0]       pwm_val,
    output logic [N_CC-1:0]        cap_rise,
    output logic [N_CC-1:0]        cap_fall,
    output logic                   acc_sync,
    output logic                   aux_sync
);
    localparam int N_DATA = N_CC + N_PWM;
    localparam int N_SYNC = N_DATA + 2;

    typedef struct packed {
        logic [N_CC-1:0]   dir;
        logic [N_DATA-1:0] latch;
    } regs_t;

    regs_t r_d, r_q;

    // Register file: next state
    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                ADDR_DATA: r_d.latch = bus_wdata;
                ADDR_DIR:  r_d.dir   = bus_wdata[N_CC-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Pin multiplexing
    logic [N_DATA-1:0] eff;

    tsio_pin_mux #(.N_CC(N_CC), .N_PWM(N_PWM)) u_mux (
        .dir       (r_q.dir),
        .latch     (r_q.latch),
        .cmp_en    (cmp_en),
        .cmp_val   (cmp_val),
        .pwm_en    (pwm_en),
        .pwm_val   (pwm_val),
        .cc_pin_in (cc_pin_in),
        .cc_out    (cc_pin_out),
        .cc_oe     (cc_pin_oe),
        .pwm_out   (pwm_pin_out),
        .eff       (eff)
    );

    // Synchronize effective levels plus the two input-only lines
    logic [N_SYNC-1:0] sync_in, sync_out;
    assign sync_in = {aux_pin_in, acc_pin_in, eff};

    tsio_sync #(.W(N_SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .dout  (sync_out)
    );

    assign acc_sync = sync_out[N_DATA];
    assign aux_sync = sync_out[N_DATA+1];

    // Capture edge detection on capture/compare pins
    tsio_edge #(.W(N_CC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_out[N_CC-1:0]),
        .rise  (cap_rise),
        .fall  (cap_fall)
    );

    // Readback
    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            ADDR_DATA: bus_rdata = sync_out[N_DATA-1:0];
            ADDR_DIR:  bus_rdata[N_CC-1:0] = r_q.dir;
            ADDR_STAT: begin
                bus_rdata[STAT_ACC_BIT] = acc_sync;
                bus_rdata[STAT_AUX_BIT] = aux_sync;
            end
            default:   bus_rdata = '0;
        endcase
    end

    // Checks
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r_q == '0));

    for (genvar i = 0; i < N_CC; i++) begin : g_chk
        p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_en[i] && $past(cmp_en[i]) && $stable(cmp_val[i]))
            |-> $stable(cc_pin_out[i]));
        p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(cmp_en[i]) && r_q.dir[i])
            |-> (cc_pin_oe[i] && cc_pin_out[i] == r_q.latch[i]));
        p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmp_en[i] && !r_q.dir[i]) |-> !cc_pin_oe[i]);
        p_cmp_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_en[i] |-> (cc_pin_oe[i] && cc_pin_out[i] == cmp_val[i]));
    end
endmodule

// File: tb/test_tsio_port.sv
`timescale 1ns/100ps
module test_tsio_port;
    localparam int N_CC  = 4;
    localparam int N_PWM = 2;
    localparam int N_D   = N_CC + N_PWM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [N_D-1:0] bus_wdata = '0;
    logic [N_D-1:0] bus_rdata;
    logic [N_CC-1:0] cc_pin_in = '0;
    logic [N_CC-1:0] cc_pin_out, cc_pin_oe;
    logic [N_PWM-1:0] pwm_pin_out;
    logic acc_pin_in = 1'b0, aux_pin_in = 1'b0;
    logic [N_CC-1:0] cmp_en = '0, cmp_val = '0;
    logic [N_PWM-1:0] pwm_en = '0, pwm_val = '0;
    logic [N_CC-1:0] cap_rise, cap_fall;
    logic acc_sync, aux_sync;

    always #2.5 clk = ~clk;

    tsio_port #(.N_CC(N_CC), .N_PWM(N_PWM)) i_tsio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cc_pin_in(cc_pin_in),
        .cc_pin_out(cc_pin_out), .cc_pin_oe(cc_pin_oe), .pwm_pin_out(pwm_pin_out),
        .acc_pin_in(acc_pin_in), .aux_pin_in(aux_pin_in), .cmp_en(cmp_en),
        .cmp_val(cmp_val), .pwm_en(pwm_en), .pwm_val(pwm_val),
        .cap_rise(cap_rise), .cap_fall(cap_fall), .acc_sync(acc_sync),
        .aux_sync(aux_sync)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [3:0] dir;
        logic [5:0] data;
        logic [3:0] cen;
        logic [3:0] cval;
        logic [1:0] pen;
        logic [1:0] pval;
        logic [3:0] ext;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{4'b0000, 6'b000000, 4'b0000, 4'b0000, 2'b00, 2'b00, 4'b1010},
        '{4'b1111, 6'b110101, 4'b0000, 4'b0000, 2'b00, 2'b00, 4'b0000},
        '{4'b0011, 6'b001010, 4'b0000, 4'b0000, 2'b00, 2'b00, 4'b0101},
        '{4'b1111, 6'b001111, 4'b0101, 4'b0000, 2'b01, 2'b01, 4'b0000},
        '{4'b0000, 6'b100000, 4'b1100, 4'b1000, 2'b10, 2'b00, 4'b0011},
        '{4'b1001, 6'b010110, 4'b0010, 4'b0010, 2'b11, 2'b10, 4'b0100}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [N_D-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [N_D-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N_D-1:0] rd;
        logic [3:0] e_oe, e_val;
        logic [1:0] e_pwm;
        bit seen;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R7: reset state
        bus_read(2'd1, rd);
        check("R7 dir reset", 16'(rd), 16'h0);
        check("R7 oe reset", 16'(cc_pin_oe), 16'h0);
        check("R7 latch reset via pwm pins", 16'(pwm_pin_out), 16'h0);

        // Vector table: R2 R3 R10 R12
        for (int k = 0; k < 6; k++) begin
            bus_write(2'd1, {2'b00, VECS[k].dir});
            bus_write(2'd0, VECS[k].data);
            cmp_en = VECS[k].cen; cmp_val = VECS[k].cval;
            pwm_en = VECS[k].pen; pwm_val = VECS[k].pval;
            cc_pin_in = VECS[k].ext;
            repeat (3) tick();
            for (int i = 0; i < 4; i++) begin
                e_oe[i]  = VECS[k].cen[i] | VECS[k].dir[i];
                e_val[i] = VECS[k].cen[i] ? VECS[k].cval[i] :
                           (VECS[k].dir[i] ? VECS[k].data[i] : VECS[k].ext[i]);
            end
            for (int j = 0; j < 2; j++)
                e_pwm[j] = VECS[k].pen[j] ? VECS[k].pval[j] : VECS[k].data[4+j];
            bus_read(2'd0, rd);
            check("R3 readback", 16'(rd), 16'({e_pwm, e_val}));
            check("R2/R12 output enable", 16'(cc_pin_oe), 16'(e_oe));
            check("R10 pwm output", 16'(pwm_pin_out), 16'(e_pwm));
        end

        // R11 register map
        cmp_en = '0; pwm_en = '0; cc_pin_in = '0;
        bus_write(2'd1, 6'b111111);
        bus_read(2'd1, rd);
        check("R11 dir upper bits zero", 16'(rd), 16'h000F);
        bus_write(2'd3, 6'b101010);
        bus_write(2'd2, 6'b010101);
        bus_read(2'd3, rd);
        check("R11 addr3 reads zero", 16'(rd), 16'h0);
        bus_read(2'd1, rd);
        check("R11 stray writes ignored", 16'(rd), 16'h000F);

        // R6: latch write creates a capture edge two clocks later
        bus_write(2'd1, 6'b000001);
        bus_write(2'd0, 6'b000000);
        repeat (4) tick();
        bus_write(2'd0, 6'b000001);
        tick();
        check("R6 no strobe one clock after write", 16'(cap_rise[0]), 16'h0);
        tick();
        check("R6 rise strobe from latch write", 16'(cap_rise[0]), 16'h1);
        tick();
        check("R6 strobe lasts one clock", 16'(cap_rise[0]), 16'h0);

        // R4/R5: write held under compare, released afterwards
        cmp_en[0] = 1'b1; cmp_val[0] = 1'b1;
        repeat (4) tick();
        bus_write(2'd0, 6'b000000);
        check("R4 pin unchanged by write", 16'(cc_pin_out[0]), 16'h1);
        repeat (3) tick();
        bus_read(2'd0, rd);
        check("R4 readback shows compare level", 16'(rd[0]), 16'h1);
        cmp_en[0] = 1'b0;
        #0.5;
        check("R5 latch value drives after release", 16'(cc_pin_out[0]), 16'h0);
        check("R5 pin still driven", 16'(cc_pin_oe[0]), 16'h1);
        tick(); tick();
        check("R6 fall strobe after release", 16'(cap_fall[0]), 16'h1);

        // R6 external input edge on an input pin
        bus_write(2'd1, 6'b000000);
        cc_pin_in[1] = 1'b0;
        repeat (4) tick();
        cc_pin_in[1] = 1'b1;
        tick(); tick();
        check("R6 rise from pin", 16'(cap_rise[1]), 16'h1);
        cc_pin_in[1] = 1'b0;
        tick(); tick();
        check("R6 fall from pin", 16'(cap_fall[1]), 16'h1);
        repeat (3) tick();

        // R9: sub-cycle glitch between edges is ignored
        #1 cc_pin_in[2] = 1'b1;
        #1 cc_pin_in[2] = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 5; c++) begin
            tick();
            if (cap_rise[2]) seen = 1'b1;
        end
        check("R9 short glitch ignored", 16'(seen), 16'h0);

        // R9: three-clock pulse is seen
        cc_pin_in[2] = 1'b1;
        seen = 1'b0;
        for (int c = 0; c < 6; c++) begin
            tick();
            if (c == 2) cc_pin_in[2] = 1'b0;
            if (cap_rise[2]) seen = 1'b1;
        end
        check("R9 long pulse seen", 16'(seen), 16'h1);

        // R8 / R1: input-only lines readable as status
        acc_pin_in = 1'b1;
        tick(); tick();
        bus_read(2'd2, rd);
        check("R8 accumulator status bit0", 16'(rd), 16'h1);
        check("R1 accumulator line synchronized", 16'(acc_sync), 16'h1);
        acc_pin_in = 1'b0; aux_pin_in = 1'b1;
        tick(); tick();
        bus_read(2'd2, rd);
        check("R8 aux clock status bit1", 16'(rd), 16'h2);
        check("R8 aux sync output", 16'(aux_sync), 16'h1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule